// File: doc/BRIEF.md
# SPI Flash Boot Image Reader

This block runs once after reset. It pulls a boot image out of a serial flash over a mode 0 SPI link. It lowers chip select and shifts out a read opcode followed by a 24-bit start address. Then it reads the image back.

The image is framed by its own contents. It starts with a 32-bit word count. That many 32-bit program words follow, and a 32-bit checksum word closes the image. Every received byte arrives least-significant bit first. Every multi-byte word arrives least-significant byte first.

Each reassembled byte leaves on a one-cycle valid strobe, tagged with the part of the image it belongs to. At the end, chip select is released and a done pulse is given. If the word count is larger than the block is built to accept, the read is cut short and a sticky error flag is raised. The SCLK rate is a parameter, given in system clocks per SCLK period. Its default of 40 yields 2.5 MHz from a 100 MHz clock.

Top module: `boot_flash_fetch`

## Requirements
- R1: After reset is released, chip select goes low and MOSI carries the opcode 0x03 and then the 24-bit address, 32 bits in all, most significant bit first. MOSI is 0 while the image is read.
- R2: SCLK idles low and has a period of CLK_DIV system clocks, high for CLK_DIV/2 of them. MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R3: Each received byte is reassembled least-significant bit first: the first MISO bit after a byte boundary is bit 0 of img_byte.
- R4: The first four image bytes are the word count, least-significant byte first, and are emitted with img_role = 1.
- R5: Exactly word count × 4 program bytes follow, emitted in arrival order with img_role = 2. No byte is emitted outside an active transfer.
- R6: Four checksum bytes follow the program, emitted with img_role = 3. A word count of 0 goes straight from the count to the checksum.
- R7: Chip select rises exactly one SCLK period (CLK_DIV clocks) after the rising edge that samples the last bit, with no SCLK edge in between. img_done pulses for one cycle while chip select is high.
- R8: A word count above MAX_WORDS sets img_size_err, which stays set until reset. No program or checksum byte is then emitted, and chip select is released and done pulsed as in R7.
- R9: While chip select is high, SCLK is low. After done, SPI and output activity stay idle until the next reset. During reset every output is idle: chip select high, SCLK low, the strobes low and the error flag clear.
- R10: The address sent is the value on boot_addr when the transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the fetch |
| boot_addr | input | 24 | Flash start address sent after the opcode |
| spi_miso | input | 1 | Serial data from the flash |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial command and address to the flash |
| spi_ss_n | output | 1 | Active-low flash chip select |
| img_valid | output | 1 | One-cycle strobe for each received byte |
| img_byte | output | 8 | Reassembled byte |
| img_role | output | 2 | 1 word count, 2 program, 3 checksum |
| img_done | output | 1 | One-cycle pulse at the end of the transfer |
| img_size_err | output | 1 | Sticky flag: word count above MAX_WORDS |

## Verification
The assertions check the link-level rules on every cycle:
- SCLK stays low while chip select is high.
- MOSI holds steady through each SCLK high phase, and each high phase lasts exactly CLK_DIV/2 clocks.
- Bytes appear only during a transfer.
- Done is a single-cycle pulse given with chip select high.
- The error flag is sticky, and once it is set only count bytes are emitted.

Only the bench scenarios can show the content-dependent behaviour: the serialised command and address, least-significant-bit-first byte assembly, exact byte counts and role tags for zero, mid-size and maximum word counts, the oversize abort, and the one-period chip-select release delay.

// File: rtl/bootfetch_pkg.sv
package bootfetch_pkg;

  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_SIZE = 2'd1,
    ROLE_PROG = 2'd2,
    ROLE_CSUM = 2'd3
  } byte_role_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_SIZE,
    ST_BODY,
    ST_CSUM,
    ST_TAIL,
    ST_DONE,
    ST_HALT
  } fetch_st_e;

  localparam logic [7:0] READ_OPCODE = 8'h03;

  // Command word shifted out MSB first: opcode then address
  function automatic logic [31:0] cmd_frame(input logic [23:0] addr);
    return {READ_OPCODE, addr};
  endfunction

  // New bit enters at the top; after eight pushes the first bit sits at bit 0
  function automatic logic [7:0] lsb_first_push(input logic [7:0] acc, input logic b);
    return {b, acc[7:1]};
  endfunction

  // New byte enters at the top; after four pushes the first byte is the low byte
  function automatic logic [31:0] le_word_push(input logic [31:0] w, input logic [7:0] b);
    return {b, w[31:8]};
  endfunction

  function automatic logic size_too_big(input logic [31:0] words, input logic [31:0] lim);
    return words > lim;
  endfunction

  function automatic logic [31:0] words_to_bytes(input logic [31:0] words);
    return words << 2;
  endfunction

  function automatic logic st_active(input fetch_st_e s);
    return (s == ST_CMD) || (s == ST_SIZE) || (s == ST_BODY) ||
           (s == ST_CSUM) || (s == ST_TAIL);
  endfunction

  function automatic logic st_receiving(input fetch_st_e s);
    return (s == ST_SIZE) || (s == ST_BODY) || (s == ST_CSUM);
  endfunction

  function automatic byte_role_e role_of(input fetch_st_e s);
    case (s)
      ST_SIZE: return ROLE_SIZE;
      ST_BODY: return ROLE_PROG;
      ST_CSUM: return ROLE_CSUM;
      default: return ROLE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bf_sclk_gen.sv
module bf_sclk_gen #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold_low,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  // Tick positions inside one SCLK period; a rise tick is still produced
  // while hold_low is set so the tail can time one full period
  assign rise_evt = run && (cnt == CW'(HALF - 1));
  assign fall_evt = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (fall_evt) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sclk <= 1'b0;
    else if (!run)                  sclk <= 1'b0;
    else if (rise_evt && !hold_low) sclk <= 1'b1;
    else if (fall_evt)              sclk <= 1'b0;
  end

endmodule

// File: rtl/bf_shift.sv
module bf_shift
  import bootfetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [23:0] addr,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        rx_en,
  input  logic        miso,
  output logic        mosi,
  output logic        rx_done,
  output logic [7:0]  rx_byte
);
  logic [31:0] tx_sh;
  logic [7:0]  rx_sh;
  logic [2:0]  bit_idx;

  assign mosi    = tx_sh[31];
  assign rx_byte = lsb_first_push(rx_sh, miso);
  assign rx_done = rise_evt && rx_en && (bit_idx == 3'd7);

  // Transmit: MSB first, advanced on the falling tick, zeros fill behind
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_sh <= '0;
    else if (load)     tx_sh <= cmd_frame(addr);
    else if (fall_evt) tx_sh <= {tx_sh[30:0], 1'b0};
  end

  // Receive: sample on the rising tick, LSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      bit_idx <= '0;
    end else if (load) begin
      rx_sh   <= '0;
      bit_idx <= '0;
    end else if (rise_evt && rx_en) begin
      rx_sh   <= rx_byte;
      bit_idx <= bit_idx + 3'd1;
    end
  end

endmodule

// File: rtl/bf_frame.sv
module bf_frame
  import bootfetch_pkg::*;
#(
  parameter int MAX_WORDS = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_evt,
  input  logic       rx_done,
  input  logic [7:0] rx_byte,
  output logic       run,
  output logic       hold_low,
  output logic       load,
  output logic       rx_en,
  output logic       ss_n,
  output logic       done,
  output logic       size_err,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [1:0] byte_role
);
  localparam int BW = $clog2(MAX_WORDS * 4 + 1);

  fetch_st_e      st, nxt;
  logic [4:0]     cmd_cnt;
  logic [1:0]     quad;
  logic [31:0]    size_sh;
  logic [31:0]    size_full;
  logic [BW-1:0]  body_left;
  logic           size_last;
  logic           size_bad;

  assign run       = st_active(st);
  assign rx_en     = st_receiving(st);
  assign hold_low  = (st == ST_TAIL);
  assign load      = (st == ST_IDLE);
  assign size_full = le_word_push(size_sh, rx_byte);
  assign size_last = (st == ST_SIZE) && rx_done && (quad == 2'd3);
  assign size_bad  = size_too_big(size_full, 32'(MAX_WORDS));

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: nxt = ST_CMD;
      ST_CMD:  if (rise_evt && cmd_cnt == 5'd31) nxt = ST_SIZE;
      ST_SIZE: if (size_last) begin
                 if (size_bad)              nxt = ST_TAIL;
                 else if (size_full == '0)  nxt = ST_CSUM;
                 else                       nxt = ST_BODY;
               end
      ST_BODY: if (rx_done && body_left == BW'(1)) nxt = ST_CSUM;
      ST_CSUM: if (rx_done && quad == 2'd3) nxt = ST_TAIL;
      ST_TAIL: if (rise_evt) nxt = ST_DONE;
      ST_DONE: nxt = ST_HALT;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ss_n <= 1'b1;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      ss_n <= !st_active(nxt);
      done <= (nxt == ST_DONE);
    end
  end

  // Command bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cmd_cnt <= '0;
    else if (load)                        cmd_cnt <= '0;
    else if (st == ST_CMD && rise_evt)    cmd_cnt <= cmd_cnt + 5'd1;
  end

  // Byte-within-word counter for the count and checksum words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    quad <= '0;
    else if (load) quad <= '0;
    else if (rx_done && (st == ST_SIZE || st == ST_CSUM)) quad <= quad + 2'd1;
  end

  // Word count assembly and program byte budget
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_sh   <= '0;
      body_left <= '0;
    end else if (load) begin
      size_sh   <= '0;
      body_left <= '0;
    end else if (st == ST_SIZE && rx_done) begin
      size_sh <= size_full;
      if (size_last && !size_bad) body_left <= BW'(words_to_bytes(size_full));
    end else if (st == ST_BODY && rx_done) begin
      body_left <= body_left - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   size_err <= 1'b0;
    else if (size_last && size_bad) size_err <= 1'b1;
  end

  // Output byte stage: one cycle after the completing edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_role  <= ROLE_NONE;
    end else begin
      byte_valid <= rx_done;
      if (rx_done) begin
        byte_data <= rx_byte;
        byte_role <= role_of(st);
      end
    end
  end

endmodule

// File: rtl/boot_flash_fetch.sv
module boot_flash_fetch
  import bootfetch_pkg::*;
#(
  parameter int CLK_DIV   = 40,
  parameter int MAX_WORDS = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] boot_addr,
  input  logic        spi_miso,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_ss_n,
  output logic        img_valid,
  output logic [7:0]  img_byte,
  output logic [1:0]  img_role,
  output logic        img_done,
  output logic        img_size_err
);
  // Named internal events
  logic       sclk_rise;
  logic       sclk_fall;
  logic       frame_run;
  logic       tail_hold;
  logic       cmd_load;
  logic       rx_active;
  logic       rx_strobe;
  logic [7:0] rx_value;

  bf_sclk_gen #(.DIV(CLK_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (frame_run),
    .hold_low (tail_hold),
    .sclk     (spi_sclk),
    .rise_evt (sclk_rise),
    .fall_evt (sclk_fall)
  );

  bf_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_load),
    .addr     (boot_addr),
    .rise_evt (sclk_rise),
    .fall_evt (sclk_fall),
    .rx_en    (rx_active),
    .miso     (spi_miso),
    .mosi     (spi_mosi),
    .rx_done  (rx_strobe),
    .rx_byte  (rx_value)
  );

  bf_frame #(.MAX_WORDS(MAX_WORDS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt   (sclk_rise),
    .rx_done    (rx_strobe),
    .rx_byte    (rx_value),
    .run        (frame_run),
    .hold_low   (tail_hold),
    .load       (cmd_load),
    .rx_en      (rx_active),
    .ss_n       (spi_ss_n),
    .done       (img_done),
    .size_err   (img_size_err),
    .byte_valid (img_valid),
    .byte_data  (img_byte),
    .byte_role  (img_role)
  );

endmodule

// File: rtl/bf_check.sv
module bf_check #(
  parameter int DIV = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_ss_n,
  input logic       sclk_rise,
  input logic       img_valid,
  input logic [1:0] img_role,
  input logic       img_done,
  input logic       img_size_err
);
  localparam int HALF = DIV / 2;

  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (spi_sclk) hi_cnt <= hi_cnt + 16'd1;
    else               hi_cnt <= '0;
  end

  p_idle_sclk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> !spi_sclk);

  p_mosi_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_high_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> (hi_cnt == 16'(HALF)));

  p_tick_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |-> !spi_ss_n);

  p_byte_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    img_valid |-> (!spi_ss_n && img_role != 2'd0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    img_done |=> !img_done);

  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    img_done |-> spi_ss_n);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    img_size_err |=> img_size_err);

  p_err_count_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (img_size_err && img_valid) |-> (img_role == 2'd1));

endmodule

bind boot_flash_fetch bf_check #(.DIV(CLK_DIV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spi_sclk     (spi_sclk),
  .spi_mosi     (spi_mosi),
  .spi_ss_n     (spi_ss_n),
  .sclk_rise    (sclk_rise),
  .img_valid    (img_valid),
  .img_role     (img_role),
  .img_done     (img_done),
  .img_size_err (img_size_err)
);

// File: tb/sim_boot_flash_fetch.sv
module sim_boot_flash_fetch;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int MAXW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] boot_addr = '0;
  logic        spi_miso = 1'b0;
  wire         spi_sclk, spi_mosi, spi_ss_n;
  wire         img_valid, img_done, img_size_err;
  wire [7:0]   img_byte;
  wire [1:0]   img_role;

  always #5 clk = ~clk;

  boot_flash_fetch #(.CLK_DIV(DIV), .MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
    .img_valid(img_valid), .img_byte(img_byte), .img_role(img_role),
    .img_done(img_done), .img_size_err(img_size_err)
  );

  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [7:0]  img_q[$];
  logic [9:0]  exp_q[$];
  logic [9:0]  exp_item;
  logic [31:0] cmd_seen = '0;
  bit          cmd_fresh = 0;
  longint      cyc = 0;
  longint      last_rise = 0;
  bit          have_rise = 0;
  logic        prev_sclk = 1'b0;
  logic        prev_ss = 1'b1;
  int          done_cnt = 0;
  bit          exp_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string role_req(input logic [1:0] r);
    case (r)
      2'd1:    return "R3/R4 count byte";
      2'd2:    return "R3/R5 program byte";
      default: return "R3/R6 checksum byte";
    endcase
  endfunction

  // Driver side: image bytes to the flash model, expected items to the scoreboard
  task automatic push_word(input logic [1:0] role, input logic [31:0] w, input bit expect_it);
    for (int k = 0; k < 4; k++) begin
      img_q.push_back(w[8*k +: 8]);
      if (expect_it) exp_q.push_back({role, w[8*k +: 8]});
    end
  endtask

  // Flash model: capture 32 command bits, then drive image LSB first on falling SCLK
  initial begin : flash_model
    int         bn;
    logic [7:0] cur;
    forever begin
      @(negedge spi_ss_n);
      cmd_seen = '0;
      for (int i = 0; i < 32; i++) begin
        @(posedge spi_sclk);
        cmd_seen = {cmd_seen[30:0], spi_mosi};
      end
      cmd_fresh = 1;
      bn = 0;
      cur = '0;
      forever begin
        @(negedge spi_sclk or posedge spi_ss_n);
        if (spi_ss_n) break;
        if (bn == 0) cur = (img_q.size() > 0) ? img_q.pop_front() : 8'h00;
        spi_miso = cur[bn];
        bn = (bn + 1) % 8;
      end
    end
  end

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (img_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R5", "unexpected byte", {img_role, img_byte}, 0);
        end else begin
          exp_item = exp_q.pop_front();
          check({img_role, img_byte} == exp_item, role_req(exp_item[9:8]),
                "role+byte", {img_role, img_byte}, exp_item);
        end
      end
      if (spi_sclk && !prev_sclk) begin
        if (have_rise) check(cyc - last_rise == DIV, "R2", "sclk period", cyc - last_rise, DIV);
        last_rise = cyc;
        have_rise = 1;
      end
      if (!spi_sclk && prev_sclk)
        check(cyc - last_rise == HALF, "R2", "sclk high time", cyc - last_rise, HALF);
      if (spi_ss_n && !prev_ss)
        check(cyc - last_rise == DIV, "R7", "ss release delay", cyc - last_rise, DIV);
      if (!spi_ss_n && prev_ss) have_rise = 0;
      if (img_done) begin
        done_cnt++;
        check(spi_ss_n == 1'b1, "R7", "ss high at done", spi_ss_n, 1);
        check(img_size_err == exp_err, "R8", "error flag at done", img_size_err, exp_err);
      end
    end
    prev_sclk = spi_sclk;
    prev_ss   = spi_ss_n;
  end

  task automatic run_case(input logic [23:0] addr, input int words);
    bit over;
    bit quiet;
    over = (words > MAXW);
    @(negedge clk);
    rst_n = 1'b0;
    img_q.delete();
    exp_q.delete();
    exp_err = over;
    done_cnt = 0;
    cmd_fresh = 0;
    boot_addr = addr;
    repeat (2) @(negedge clk);
    // R9: idle outputs during reset
    check(spi_ss_n && !spi_sclk && !img_valid && !img_done && !img_size_err,
          "R9", "reset state", {spi_ss_n, spi_sclk, img_valid, img_done, img_size_err}, 5'b10000);
    push_word(2'd1, 32'(words), 1'b1);
    for (int w = 0; w < words; w++)
      push_word(2'd2, (32'h9E37_79B9 * (w + 1)) ^ {addr, 8'h5A}, !over);
    push_word(2'd3, 32'hC3A5_0F1E ^ 32'(words), !over);
    rst_n = 1'b1;
    while (done_cnt == 0) @(negedge clk);
    check(cmd_fresh && cmd_seen[31:24] == 8'h03, "R1", "opcode", cmd_seen[31:24], 8'h03);
    check(cmd_seen[23:0] == addr, "R10", "address", cmd_seen[23:0], addr);
    check(exp_q.size() == 0, "R5", "bytes left unreceived", exp_q.size(), 0);
    check(img_size_err == over, "R8", "error flag", img_size_err, over);
    quiet = 1;
    repeat (3 * DIV) begin
      @(negedge clk);
      if (!spi_ss_n || spi_sclk || img_valid || img_done || !spi_mosi === 1'bx) quiet = 0;
    end
    check(quiet, "R9", "quiet after done", !quiet, 0);
    check(done_cnt == 1, "R7", "single done pulse", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_case(24'h000000, 3);      // R4 R5 R6 basic image
    run_case(24'h0A5C31, 0);      // R6 empty program, R10 address
    run_case(24'h7F00E2, MAXW);   // R5 largest accepted count
    run_case(24'h000100, MAXW + 4); // R8 oversize abort
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule